// File: doc/BRIEF.md
# System Control Register with ROM-Done Handshake

This block is an 8-bit control register for a small controller. It holds four live fields. A debug-port enable defaults to on. A password-lock flag is forced to 1 only by power-on reset. A code/data mapping select is the third field. The fourth is a "ROM operation done" flag that software can set but only hardware can clear. Software reaches the register through a plain write strobe and a read-data bus. The enable and select fields drive level outputs to the logic they govern.

When software writes a 1 to the done flag, the block starts a handshake with an external control unit. The flag is shown on a done output and stays there until the control unit's acknowledge is sampled high. The same write also revokes the debug and I2C special-mode permissions, which are held outside this block: the block emits a one-cycle clear pulse for each permission that is currently set. If the debug permission is set at the time of the write, the block also emits a one-cycle system-reset request.

The register has two asynchronous, active-low resets. Power-on reset initialises every field. The general reset initialises every field except the password lock, which keeps its value. The bus is a plain control interface with no back-pressure: a write is taken on every rising clock edge where the write strobe is high.

Top module: `sysctl_reg`

## Requirements
- R1: After power-on reset the register reads 8'h82. Debug-port enable (bit 7) is 1, password lock (bit 1) is 1, and code/data select (bit 0) and done (bit 2) are 0.
- R2: General reset (without power-on reset) returns bit 7 to 1 and bits 0 and 2 to 0, and leaves the password lock (bit 1) at its previous value.
- R3: Bits 3 to 6 always read 0, whatever was written.
- R4: A write updates bits 7, 1 and 0 at the clock edge. The outputs tap_en_o, pwd_lock_o and cda_sel_o equal those bits.
- R5: Writing 1 to bit 2 sets the done flag at the clock edge. done_o equals bit 2 and stays 1 until done_ack_i is sampled high.
- R6: When done_ack_i is sampled high with no setting write in the same cycle, the done flag clears at that edge. Writing 0 to bit 2 has no effect on the flag.
- R7: A write with bit 2 = 1 while dbg_spe_i is high gives sys_rst_req_o high for exactly the one cycle after the write edge. With dbg_spe_i low, no request is made.
- R8: A write with bit 2 = 1 gives a one-cycle dbg_spe_clr_o pulse if dbg_spe_i is high, and a one-cycle i2c_spe_clr_o pulse if i2c_spe_i is high. A permission that is clear gets no pulse.
- R9: A setting write and an acknowledge in the same cycle leave the done flag set.
- R10: In any cycle after an edge with no setting write, sys_rst_req_o, dbg_spe_clr_o and i2c_spe_clr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | General reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| dbg_spe_i | input | 1 | Current debug special-mode permission |
| i2c_spe_i | input | 1 | Current I2C special-mode permission |
| dbg_spe_clr_o | output | 1 | One-cycle clear pulse for the debug permission |
| i2c_spe_clr_o | output | 1 | One-cycle clear pulse for the I2C permission |
| done_o | output | 1 | ROM-done indication to the control unit |
| done_ack_i | input | 1 | Acknowledge of the done indication |
| sys_rst_req_o | output | 1 | One-cycle system-reset request |
| tap_en_o | output | 1 | Debug-port pin enable |
| pwd_lock_o | output | 1 | Password-lock flag |
| cda_sel_o | output | 1 | Code/data mapping select |

## Verification
Each result of a write or an acknowledge appears exactly one rising edge after the stimulus is sampled: the register fields, done_o and the three pulses are all registered. Each pulse lasts only that one cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and compares every output at the next falling edge, so each pulse is seen in its single valid cycle and is also seen to be gone in the cycle after. Asynchronous resets act at once, and their effect is checked a delta after the reset input falls.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_CFG  = 3;

  // bit positions of the live fields
  localparam int TAP_POS  = 7;
  localparam int ROD_POS  = 2;
  localparam int PWL_POS  = 1;
  localparam int CDA_POS  = 0;

  // per-field description of the plain configuration bits
  localparam int CFG_POS      [NUM_CFG] = '{TAP_POS, PWL_POS, CDA_POS};
  localparam bit CFG_RST      [NUM_CFG] = '{1'b1, 1'b1, 1'b0};
  localparam bit CFG_POR_ONLY [NUM_CFG] = '{1'b0, 1'b1, 1'b0};

  localparam int IDX_TAP = 0;
  localparam int IDX_PWL = 1;
  localparam int IDX_CDA = 2;
endpackage

// File: rtl/sysctl_cfg_bit.sv
module sysctl_cfg_bit #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    q <= RST_VAL;
    else if (wr_en) q <= wr_bit;
  end
endmodule

// File: rtl/sysctl_done_hs.sv
module sysctl_done_hs (
  input  logic clk,
  input  logic arst_n,
  input  logic wr_en,
  input  logic wr_done_bit,
  input  logic ack_i,
  input  logic dbg_spe_i,
  input  logic i2c_spe_i,
  output logic done_q,
  output logic rst_req_q,
  output logic dbg_clr_q,
  output logic i2c_clr_q
);
  logic set_req;
  assign set_req = wr_en & wr_done_bit;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      done_q    <= 1'b0;
      rst_req_q <= 1'b0;
      dbg_clr_q <= 1'b0;
      i2c_clr_q <= 1'b0;
    end else begin
      rst_req_q <= set_req & dbg_spe_i;
      dbg_clr_q <= set_req & dbg_spe_i;
      i2c_clr_q <= set_req & i2c_spe_i;
      // a setting write takes priority over an acknowledge
      if (set_req)    done_q <= 1'b1;
      else if (ack_i) done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sysctl_rd_pack.sv
module sysctl_rd_pack
  import sysctl_pkg::*;
(
  input  logic [NUM_CFG-1:0] cfg_q,
  input  logic               done_q,
  output logic [REG_W-1:0]   rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CFG; i++) rd_data[CFG_POS[i]] = cfg_q[i];
    rd_data[ROD_POS] = done_q;
  end
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dbg_spe_i,
  input  logic             i2c_spe_i,
  output logic             dbg_spe_clr_o,
  output logic             i2c_spe_clr_o,
  output logic             done_o,
  input  logic             done_ack_i,
  output logic             sys_rst_req_o,
  output logic             tap_en_o,
  output logic             pwd_lock_o,
  output logic             cda_sel_o
);
  logic               rst_any_n;
  logic [NUM_CFG-1:0] cfg_q;
  logic               done_q;
  logic               unused_rsv;

  assign rst_any_n  = por_n & rst_n;
  assign unused_rsv = ^wr_data;

  // plain configuration bits; the password lock sees power-on reset only
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic bit_rst_n;
    if (CFG_POR_ONLY[g]) begin : g_por
      assign bit_rst_n = por_n;
    end else begin : g_any
      assign bit_rst_n = rst_any_n;
    end
    sysctl_cfg_bit #(.RST_VAL(CFG_RST[g])) u_bit (
      .clk    (clk),
      .arst_n (bit_rst_n),
      .wr_en  (wr_en),
      .wr_bit (wr_data[CFG_POS[g]]),
      .q      (cfg_q[g])
    );
  end

  sysctl_done_hs u_hs (
    .clk         (clk),
    .arst_n      (rst_any_n),
    .wr_en       (wr_en),
    .wr_done_bit (wr_data[ROD_POS]),
    .ack_i       (done_ack_i),
    .dbg_spe_i   (dbg_spe_i),
    .i2c_spe_i   (i2c_spe_i),
    .done_q      (done_q),
    .rst_req_q   (sys_rst_req_o),
    .dbg_clr_q   (dbg_spe_clr_o),
    .i2c_clr_q   (i2c_spe_clr_o)
  );

  sysctl_rd_pack u_rd (
    .cfg_q   (cfg_q),
    .done_q  (done_q),
    .rd_data (rd_data)
  );

  assign done_o     = done_q;
  assign tap_en_o   = cfg_q[IDX_TAP];
  assign pwd_lock_o = cfg_q[IDX_PWL];
  assign cda_sel_o  = cfg_q[IDX_CDA];
endmodule

// File: rtl/sysctl_reg_chk.sv
module sysctl_reg_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       dbg_spe_i,
  input logic       i2c_spe_i,
  input logic       dbg_spe_clr_o,
  input logic       i2c_spe_clr_o,
  input logic       done_o,
  input logic       done_ack_i,
  input logic       sys_rst_req_o,
  input logic       tap_en_o,
  input logic       pwd_lock_o,
  input logic       cda_sel_o
);
  logic set_w;
  assign set_w = wr_en & wr_data[2];

  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rd_data[6:3] == 4'b0);

  p_field_write_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wr_en |=> (tap_en_o == $past(wr_data[7]) && pwd_lock_o == $past(wr_data[1])
               && cda_sel_o == $past(wr_data[0])));

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (done_o && !done_ack_i) |=> done_o);

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (done_ack_i && !set_w) |=> !done_o);

  p_rst_req_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (set_w && dbg_spe_i) |=> sys_rst_req_o);

  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    sys_rst_req_o |=> !sys_rst_req_o || $past(set_w));

  p_i2c_clr_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (set_w && i2c_spe_i) |=> i2c_spe_clr_o);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    set_w |=> done_o);

  p_quiet_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !set_w |=> !(sys_rst_req_o || dbg_spe_clr_o || i2c_spe_clr_o));
endmodule

bind sysctl_reg sysctl_reg_chk u_chk (.*);

// File: tb/sysctl_reg_tb.sv
module sysctl_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 11;
  // {wr, wdata, dbg, i2c, ack, exp_rd, exp_done, exp_rst, exp_dclr, exp_iclr}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 clear fields
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h87, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 R5 R8 no perms
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h87, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 hold, R10
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h83, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 ack clears
    {1'b1, 8'h04, 1'b1, 1'b1, 1'b0, 8'h04, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 R8 both perms
    {1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 8'h84, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 write 0 ignored, R10
    {1'b1, 8'h05, 1'b1, 1'b0, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 set wins, R8
    {1'b1, 8'h04, 1'b0, 1'b1, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 no dbg, R8
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    {1'b1, 8'h78, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 reserved only
    {1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0}  // R4 lock on
  };

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       dbg_spe_i = 1'b0, i2c_spe_i = 1'b0, done_ack_i = 1'b0;
  logic       dbg_spe_clr_o, i2c_spe_clr_o, done_o, sys_rst_req_o;
  logic       tap_en_o, pwd_lock_o, cda_sel_o;
  int         n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_reg u_dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_fields(input string req, input logic [7:0] exp_rd);
    check(req, {8'h00, rd_data}, {8'h00, exp_rd});
    check({req, " R4 outputs"}, {13'h0, tap_en_o, pwd_lock_o, cda_sel_o},
          {13'h0, exp_rd[7], exp_rd[1], exp_rd[0]});
    check({req, " R5 done_o"}, {15'h0, done_o}, {15'h0, exp_rd[2]});
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 power-on state
    check_fields("R1 por value", 8'h82);
    check("R10 pulses idle in reset", {13'h0, sys_rst_req_o, dbg_spe_clr_o, i2c_spe_clr_o}, 16'h0);
    @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check_fields("R1 after release", 8'h82);

    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      wr_en = v[23]; wr_data = v[22:15];
      dbg_spe_i = v[14]; i2c_spe_i = v[13]; done_ack_i = v[12];
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00; dbg_spe_i = 1'b0; i2c_spe_i = 1'b0; done_ack_i = 1'b0;
      check_fields($sformatf("R3/R4/R5/R6/R9 vec %0d rd", i), v[11:4]);
      check($sformatf("R7/R8/R10 vec %0d pulses", i),
            {13'h0, sys_rst_req_o, dbg_spe_clr_o, i2c_spe_clr_o}, {13'h0, v[2:0]});
    end

    // R7 R10 pulses last one cycle only
    @(posedge clk); @(negedge clk);
    check("R7 R10 pulses gone", {13'h0, sys_rst_req_o, dbg_spe_clr_o, i2c_spe_clr_o}, 16'h0);

    // R2 general reset keeps lock = 1, clears done
    do_write(8'h07);
    check_fields("R2 pre", 8'h07);
    rst_n = 1'b0; #1;
    check_fields("R2 lock kept 1", 8'h82);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2 general reset keeps lock = 0
    do_write(8'h01);
    rst_n = 1'b0; #1;
    check_fields("R2 lock kept 0", 8'h80);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R1 power-on reset sets lock again
    do_write(8'h04);
    por_n = 1'b0; #1;
    check_fields("R1 por sets lock", 8'h82);
    @(negedge clk); por_n = 1'b1; @(negedge clk);

    // R6 acknowledge with no done pending leaves state alone
    done_ack_i = 1'b1;
    @(posedge clk); @(negedge clk);
    done_ack_i = 1'b0;
    check_fields("R6 stray ack", 8'h82);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule